// File: doc/BRIEF.md
# DMA Channel Address Stepper

This block holds one address pointer of a DMA channel (a source or a destination pointer) and works out its next value. A channel needs two instances, one for each side. Event strobes come from the channel sequencer:
- a beat strobe when a data beat completes,
- a minor strobe when an inner loop completes,
- a major strobe when the outer loop runs out.

On a beat the signed per-beat offset is added to the pointer. A power-of-two window can be selected. Inside that window only the low address bits advance and wrap, and the bits above the window stay fixed. This gives circular buffers without any software help. After the beat step, the same cycle can also apply either a signed inner-loop offset or a signed end-of-transfer adjustment.

The block checks every event against the transfer-size code. It raises three sticky flags:
- a configuration flag for a reserved size code,
- an address flag for a pointer that is not aligned to the size,
- an offset flag for a beat offset that is not aligned to the size.

While any flag is set the pointer is frozen. A clear strobe re-arms the block. A load strobe writes a new pointer directly.

Top module: `dma_addr_step`

## Requirements
- R1: After a synchronous reset the pointer is 0 and all three error flags are 0.
- R2: When `load_i` is high, the pointer takes `load_addr_i` at the next edge and the event strobes of that cycle are ignored. This holds even while error flags are set.
- R3: With window code 0, a beat adds the sign-extended 16-bit beat offset to the full pointer.
- R4: With window code n (1..31), a beat keeps pointer bits n and up unchanged, and bits n-1..0 become the low n bits of pointer plus offset. For example, n=4 gives a 16-byte ring.
- R5: A minor strobe with `minor_en_i` high adds the sign-extended `minor_off_i`. With `minor_en_i` low, a minor strobe leaves the pointer unchanged.
- R6: A major strobe adds `last_adj_i` over the full width. If a major strobe and an enabled minor strobe occur together, only the major adjustment is applied.
- R7: When a beat coincides with a minor or major strobe, the windowed beat step is applied first. The minor or major adjustment is then added to that result, all in one cycle.
- R8: The size code encodes the byte count as follows: 0→1, 1→2, 2→4, 4→16, 5→32. Codes 3, 6 and 7 are reserved. Any event with a reserved code sets `cfg_err_o`.
- R9: Any event with a pointer not a multiple of the size sets `addr_err_o`. A beat whose offset is not a multiple of the size sets `off_err_o`.
- R10: The flags stay set until `err_clr_i`. If a clear and a new error occur in the same cycle, the new error remains set.
- R11: The pointer does not change on an event when a flag is already set, or when the event itself raises an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Write pointer directly |
| load_addr_i | input | AW | Pointer value to load |
| beat_i | input | 1 | Beat completed |
| minor_i | input | 1 | Inner loop completed |
| major_i | input | 1 | Outer loop exhausted |
| beat_off_i | input | OFFW | Signed per-beat offset |
| size_i | input | 3 | Transfer-size code |
| mod_i | input | MODW | Window code, 0 = no wrap |
| minor_en_i | input | 1 | Enable inner-loop offset |
| minor_off_i | input | MINW | Signed inner-loop offset |
| last_adj_i | input | AW | Signed end-of-transfer adjustment |
| err_clr_i | input | 1 | Clear error flags |
| addr_o | output | AW | Registered pointer |
| cfg_err_o | output | 1 | Reserved size code seen |
| addr_err_o | output | 1 | Misaligned pointer seen |
| off_err_o | output | 1 | Misaligned beat offset seen |

## Verification
Every result of this block is due exactly one clock edge after the cycle in which its strobe is held. This covers the new pointer, a loaded pointer, a raised flag and a cleared flag. No output changes at any later edge. The bench drives each cycle's inputs just after a rising edge. It computes the expected pointer and flags from its own model of the requirements. It compares them just after the following rising edge, so every comparison sits one edge after its stimulus. Frozen-pointer and ignored-strobe cases are checked the same way, by showing that the pointer one edge later still equals its old value.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  // size code field and widest alignment mask (32-byte beats)
  localparam int SZW = 3;
  localparam int ALW = 5;

  typedef enum logic [SZW-1:0] {
    SZ_1B  = 3'd0,
    SZ_2B  = 3'd1,
    SZ_4B  = 3'd2,
    SZ_16B = 3'd4,
    SZ_32B = 3'd5
  } beat_size_e;

  typedef struct packed {
    logic cfg;
    logic adr;
    logic ofs;
  } err_flags_t;
endpackage

// File: rtl/addr_size_decode.sv
module addr_size_decode
  import dma_addr_pkg::*;
(
  input  logic [SZW-1:0] code_i,
  output logic [ALW-1:0] low_mask_o,
  output logic           reserved_o
);
  always_comb begin
    reserved_o = 1'b0;
    unique case (code_i)
      SZ_1B:   low_mask_o = 5'b00000;
      SZ_2B:   low_mask_o = 5'b00001;
      SZ_4B:   low_mask_o = 5'b00011;
      SZ_16B:  low_mask_o = 5'b01111;
      SZ_32B:  low_mask_o = 5'b11111;
      default: begin
        low_mask_o = 5'b00000;
        reserved_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/addr_mod_adder.sv
module addr_mod_adder #(
  parameter int AW   = 32,
  parameter int MODW = 5
) (
  input  logic [AW-1:0]   cur_i,
  input  logic [AW-1:0]   off_i,
  input  logic [MODW-1:0] mod_i,
  output logic [AW-1:0]   nxt_o
);
  logic [AW-1:0] raw;
  logic [AW-1:0] keep;

  assign raw = cur_i + off_i;

  // bit i is frozen when a window is active and i lies at or above it
  for (genvar i = 0; i < AW; i++) begin : g_keep
    localparam logic [31:0] IDX = i;
    assign keep[i] = (|mod_i) && (IDX >= 32'(mod_i));
  end

  assign nxt_o = (cur_i & keep) | (raw & ~keep);
endmodule

// File: rtl/addr_err_track.sv
module addr_err_track
  import dma_addr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  err_flags_t det_i,
  output err_flags_t flags_o
);
  always_ff @(posedge clk) begin
    if (rst)        flags_o <= '0;
    else if (clr_i) flags_o <= det_i;
    else            flags_o <= flags_o | det_i;
  end

  AST_CFG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flags_o.cfg && !clr_i) |=> flags_o.cfg);                           // R10
  AST_ADR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flags_o.adr && !clr_i) |=> flags_o.adr);                           // R10
  AST_CLR_NEW: assert property (@(posedge clk) disable iff (rst)
    (clr_i && det_i == '0) |=> (flags_o == '0));                        // R10
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_addr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int OFFW = 16,
  parameter int MINW = 20,
  parameter int MODW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [AW-1:0]   load_addr_i,
  input  logic            beat_i,
  input  logic            minor_i,
  input  logic            major_i,
  input  logic [OFFW-1:0] beat_off_i,
  input  logic [SZW-1:0]  size_i,
  input  logic [MODW-1:0] mod_i,
  input  logic            minor_en_i,
  input  logic [MINW-1:0] minor_off_i,
  input  logic [AW-1:0]   last_adj_i,
  input  logic            err_clr_i,
  output logic [AW-1:0]   addr_o,
  output logic            cfg_err_o,
  output logic            addr_err_o,
  output logic            off_err_o
);
  localparam int OEXT = AW - OFFW;
  localparam int MEXT = AW - MINW;

  logic [ALW-1:0] low_mask;
  logic           size_rsv;
  logic           any_evt;
  err_flags_t     det, flags_q;
  logic           blocked;
  logic [AW-1:0]  beat_ext, minor_ext, adj;
  logic [AW-1:0]  step1_full, step1, step2;
  logic [AW-1:0]  addr_q;

  addr_size_decode u_size (
    .code_i     (size_i),
    .low_mask_o (low_mask),
    .reserved_o (size_rsv)
  );

  assign any_evt = !load_i && (beat_i || minor_i || major_i);

  assign det.cfg = any_evt && size_rsv;
  assign det.adr = any_evt && |(addr_q[ALW-1:0] & low_mask);
  assign det.ofs = !load_i && beat_i && |(beat_off_i[ALW-1:0] & low_mask);

  addr_err_track u_err (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (err_clr_i),
    .det_i   (det),
    .flags_o (flags_q)
  );

  assign blocked = (flags_q != '0) || (det != '0);

  assign beat_ext  = {{OEXT{beat_off_i[OFFW-1]}}, beat_off_i};
  assign minor_ext = {{MEXT{minor_off_i[MINW-1]}}, minor_off_i};

  // windowed beat step
  addr_mod_adder #(.AW(AW), .MODW(MODW)) u_beat_add (
    .cur_i (addr_q),
    .off_i (beat_ext),
    .mod_i (mod_i),
    .nxt_o (step1_full)
  );

  assign step1 = beat_i ? step1_full : addr_q;

  always_comb begin
    if (major_i)                   adj = last_adj_i;
    else if (minor_i && minor_en_i) adj = minor_ext;
    else                           adj = '0;
  end

  // full-width loop adjustment after the beat step
  addr_mod_adder #(.AW(AW), .MODW(MODW)) u_loop_add (
    .cur_i (step1),
    .off_i (adj),
    .mod_i ('0),
    .nxt_o (step2)
  );

  always_ff @(posedge clk) begin
    if (rst)                      addr_q <= '0;
    else if (load_i)              addr_q <= load_addr_i;
    else if (any_evt && !blocked) addr_q <= step2;
  end

  assign addr_o     = addr_q;
  assign cfg_err_o  = flags_q.cfg;
  assign addr_err_o = flags_q.adr;
  assign off_err_o  = flags_q.ofs;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (addr_o == $past(load_addr_i)));                          // R2
  AST_FROZEN_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    (!load_i && (cfg_err_o || addr_err_o || off_err_o)) |=> $stable(addr_o)); // R11
  AST_RSV_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (!load_i && (beat_i || minor_i || major_i) &&
     (size_i == 3'd3 || size_i == 3'd6 || size_i == 3'd7)) |=> cfg_err_o);   // R8
  AST_WINDOW_UPPER: assert property (@(posedge clk) disable iff (rst)
    (!load_i && beat_i && !minor_i && !major_i && mod_i != '0) |=>
      (((addr_o ^ $past(addr_o)) >> $past(mod_i)) == '0));             // R4
  AST_MINOR_OFF: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !beat_i && !major_i && minor_i && !minor_en_i) |=> $stable(addr_o)); // R5
endmodule

// File: tb/dma_addr_step_tb.sv
module dma_addr_step_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        load_i;
  logic [31:0] load_addr_i;
  logic        beat_i, minor_i, major_i;
  logic [15:0] beat_off_i;
  logic [2:0]  size_i;
  logic [4:0]  mod_i;
  logic        minor_en_i;
  logic [19:0] minor_off_i;
  logic [31:0] last_adj_i;
  logic        err_clr_i;
  logic [31:0] addr_o;
  logic        cfg_err_o, addr_err_o, off_err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] e_addr;
  logic        e_cfg, e_adr, e_ofs;

  always #2 clk = ~clk;

  dma_addr_step dut_i (
    .clk(clk), .rst(rst), .load_i(load_i), .load_addr_i(load_addr_i),
    .beat_i(beat_i), .minor_i(minor_i), .major_i(major_i),
    .beat_off_i(beat_off_i), .size_i(size_i), .mod_i(mod_i),
    .minor_en_i(minor_en_i), .minor_off_i(minor_off_i),
    .last_adj_i(last_adj_i), .err_clr_i(err_clr_i),
    .addr_o(addr_o), .cfg_err_o(cfg_err_o),
    .addr_err_o(addr_err_o), .off_err_o(off_err_o)
  );

  // byte count per size code (R8), 0 for reserved codes
  function automatic int m_bytes(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd4: return 16;
      3'd5: return 32;
      default: return 0;
    endcase
  endfunction

  // ring arithmetic model (R3, R4)
  function automatic logic [31:0] m_wrap(input logic [31:0] cur,
                                         input logic [15:0] off,
                                         input logic [4:0] m);
    longint win, base, lo, ofs;
    ofs = longint'($signed(off));
    if (m == 0) return cur + 32'(ofs);
    win  = longint'(1) << m;
    base = longint'(cur) - (longint'(cur) % win);
    lo   = (longint'(cur) % win + ofs) % win;
    if (lo < 0) lo = lo + win;
    return 32'(base + lo);
  endfunction

  function automatic string m_tag(input logic blk);
    if (load_i) return "R2";
    if (blk) return "R11";
    if (beat_i && (minor_i || major_i)) return "R7";
    if (major_i) return "R6";
    if (minor_i) return "R5";
    if (beat_i && mod_i != 0) return "R4";
    return "R3";
  endfunction

  string cur_tag;

  task automatic model_step();
    int  nb;
    bit  evt, dc, da, dof, blk;
    logic [31:0] a;
    nb  = m_bytes(size_i);
    evt = !load_i && (beat_i || minor_i || major_i);
    dc  = evt && nb == 0;
    da  = evt && nb != 0 && (e_addr & 32'(nb - 1)) != 0;
    dof = !load_i && beat_i && nb != 0 && (beat_off_i & 16'(nb - 1)) != 0;
    blk = e_cfg || e_adr || e_ofs || dc || da || dof;
    cur_tag = m_tag(blk);
    if (load_i) e_addr = load_addr_i;
    else if (evt && !blk) begin
      a = beat_i ? m_wrap(e_addr, beat_off_i, mod_i) : e_addr;
      if (major_i) a = a + last_adj_i;
      else if (minor_i && minor_en_i) a = a + {{12{minor_off_i[19]}}, minor_off_i};
      e_addr = a;
    end
    if (err_clr_i) begin e_cfg = dc; e_adr = da; e_ofs = dof; end
    else begin e_cfg |= dc; e_adr |= da; e_ofs |= dof; end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "addr", addr_o, e_addr);
    chk(tag, "cfg_err", 32'(cfg_err_o), 32'(e_cfg));
    chk(tag, "addr_err", 32'(addr_err_o), 32'(e_adr));
    chk(tag, "off_err", 32'(off_err_o), 32'(e_ofs));
  endtask

  task automatic idle_inputs();
    load_i = 0; beat_i = 0; minor_i = 0; major_i = 0; err_clr_i = 0;
  endtask

  // apply current inputs for one cycle, then compare one edge later
  task automatic cycle(input string tag);
    string t;
    model_step();
    t = (tag == "") ? cur_tag : tag;
    @(posedge clk); #1;
    check_all(t);
    idle_inputs();
  endtask

  task automatic do_load(input logic [31:0] a);
    idle_inputs(); load_i = 1; load_addr_i = a; cycle("R2");
  endtask

  task automatic do_beat(input logic [15:0] off, input string tag);
    idle_inputs(); beat_i = 1; beat_off_i = off; cycle(tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_0A11);
    idle_inputs();
    load_addr_i = 0; beat_off_i = 0; size_i = 0; mod_i = 0;
    minor_en_i = 0; minor_off_i = 0; last_adj_i = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    e_addr = 0; e_cfg = 0; e_adr = 0; e_ofs = 0;
    check_all("R1");

    // R2 load, R3 plain beats
    size_i = 3'd2; mod_i = 0;
    do_load(32'h0000_1000);
    do_beat(16'd4, "R3");
    do_beat(16'hFFF8, "R3");

    // R4 windowed beats
    mod_i = 5'd4;
    do_load(32'h0000_20F8);
    do_beat(16'd4, "R4");
    do_beat(16'd4, "R4");
    mod_i = 5'd31;
    do_load(32'h7FFF_FFFC);
    do_beat(16'd4, "R4");
    do_load(32'hFFFF_FFFC);
    do_beat(16'd4, "R4");

    // R5 inner-loop offset and its enable
    mod_i = 0;
    do_load(32'h0000_1000);
    idle_inputs(); beat_i = 1; beat_off_i = 16'd4; minor_i = 1;
    minor_en_i = 1; minor_off_i = 20'hFFFF0; cycle("R5");
    idle_inputs(); minor_i = 1; minor_en_i = 0; cycle("R5");

    // R6 major wins over minor
    idle_inputs(); major_i = 1; minor_i = 1; minor_en_i = 1;
    last_adj_i = 32'h0000_0100; cycle("R6");

    // R7 ordering: wrap first, then adjustment
    mod_i = 5'd4;
    do_load(32'h0000_20FC);
    idle_inputs(); beat_i = 1; beat_off_i = 16'd4; major_i = 1;
    last_adj_i = 32'hFFFF_FFE0; cycle("R7");
    mod_i = 0;

    // R8 large sizes and reserved codes
    size_i = 3'd4;
    do_load(32'h0000_1010);
    do_beat(16'd16, "R8");
    size_i = 3'd5;
    do_load(32'h0000_1040);
    do_beat(16'd32, "R8");
    size_i = 3'd3;
    do_beat(16'd4, "R8");
    do_beat(16'd4, "R11");
    idle_inputs(); cycle("R10");
    idle_inputs(); err_clr_i = 1; cycle("R10");

    // R9 misalignment
    size_i = 3'd2;
    do_load(32'h0000_1002);
    do_beat(16'd4, "R9");
    idle_inputs(); err_clr_i = 1; cycle("R10");
    do_load(32'h0000_1000);
    do_beat(16'd2, "R9");
    // R10 clear and new error together
    idle_inputs(); err_clr_i = 1; beat_i = 1; beat_off_i = 16'd6; cycle("R10");
    // R2 load while flagged
    do_load(32'h0000_3000);
    idle_inputs(); err_clr_i = 1; cycle("R10");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int r;
      idle_inputs();
      r = $urandom_range(0, 99);
      load_i = (r < 3);
      load_addr_i = $urandom() & 32'hFFFF_FFE0;
      beat_i  = ($urandom_range(0, 3) != 0);
      minor_i = ($urandom_range(0, 4) == 0);
      major_i = ($urandom_range(0, 9) == 0);
      minor_en_i = $urandom_range(0, 1);
      minor_off_i = 20'($urandom());
      last_adj_i = $urandom();
      beat_off_i = 16'($urandom());
      mod_i = ($urandom_range(0, 2) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
      r = $urandom_range(0, 99);
      size_i = (r < 90) ? 3'd0 : 3'($urandom_range(0, 7));
      err_clr_i = ($urandom_range(0, 5) == 0);
      cycle("");
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule